// File: doc/BRIEF.md
# Reloadable Square-Wave Timer

This block is a 16-bit up-counter with a 16-bit reload register. It acts as a programmable clock generator. When the capture/reload select input is low and the output enable input is high, the block is in clock-out mode. In that mode the counter advances once per count enable. When it passes its all-ones value, it takes the reload value and flips the square-wave output. The output is a 50% duty clock of period 2×(65536 − reload) count enables.

Count enables come from a strobe inside the system clock domain. The strobe fires on every system clock cycle when `full_rate` is 1, and on every second cycle when it is 0. Software reaches the counter bytes, the reload bytes and the overflow flag through a byte-wide write port. An interrupt line follows the flag unless `irq_ignore` blocks it.

The output level is held in a four-state machine:
- `ST_PARK_LO` and `ST_PARK_HI` hold the level while the mode is inactive.
- `ST_RUN_LO` and `ST_RUN_HI` run the clock.
- Park to run is taken when the mode becomes active. It lands on the opposite level if an overflow occurs in the same cycle.
- Run to the opposite run state is taken on each overflow.
- Run to the park state of the same level is taken when the mode drops.

Top module: `clkout_timer`

## Requirements
- R1: The counter, output and flag change only while `cap_sel`=0 and `out_en`=1 (clock-out mode). Outside that mode they hold, except for software writes.
- R2: With `full_rate`=1 a count enable occurs on every cycle. With `full_rate`=0 it occurs on every second cycle, the first being the second cycle after reset release.
- R3: A count enable with the counter at 0xFFFF is an overflow. The counter then loads the reload value instead of wrapping to zero.
- R4: `clk_out` toggles on the cycle of each overflow, so its period is 2×(65536 − reload) count enables.
- R5: `ovf_flag` sets on every overflow. Writing data bit 0 = 0 at address 4 clears it. If the clear and an overflow fall in the same cycle, the set wins.
- R6: `irq` equals `ovf_flag` AND NOT `irq_ignore`.
- R7: The write addresses are: 0 for the counter low byte, 1 for the counter high byte, 2 for the reload low byte and 3 for the reload high byte. A counter write overrides counting in that cycle. A reload write takes effect only at the next overflow.
- R8: With reload 0xFFFF, the output toggles on every count enable.
- R9: Reset clears the counter, the reload register, `clk_out` and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_rate | input | 1 | 1: count every cycle, 0: every second cycle |
| cap_sel | input | 1 | Capture/reload select; must be 0 for clock-out |
| out_en | input | 1 | Output enable; must be 1 for clock-out |
| irq_ignore | input | 1 | Blocks the interrupt while the flag still sets |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (0..4) |
| wr_data | input | 8 | Write data |
| clk_out | output | 1 | Square-wave output |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle:
- the output flips exactly on overflow cycles and is otherwise steady;
- the counter takes the old reload value after an overflow and holds outside the mode;
- the flag sets after each overflow;
- the half-rate strobe never fires twice in a row;
- the interrupt is silent while ignored.

Only the bench's scenarios show the measured output periods for several reload values and both rates. They also show that a reload write takes effect one period late, and that the flag survives a clear written during an overflow.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
    typedef enum logic [1:0] {
        ST_PARK_LO = 2'd0,
        ST_PARK_HI = 2'd1,
        ST_RUN_LO  = 2'd2,
        ST_RUN_HI  = 2'd3
    } out_state_t;
endpackage

// File: rtl/clkout_tick.sv
module clkout_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic full_rate,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign tick = full_rate | phase_q;

    // R2: the halved strobe never fires on two adjacent cycles
    p_half_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_rate && tick) |=> !(tick && !full_rate));
endmodule

// File: rtl/clkout_counter.sv
module clkout_counter #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              ovf
);
    localparam int BYTES = WIDTH / 8;
    localparam logic [WIDTH-1:0] TOP = '1;

    logic [WIDTH-1:0] cnt_q, reload_q;
    logic [BYTES-1:0] cnt_we, rel_we;

    genvar g;
    generate
        for (g = 0; g < BYTES; g++) begin : g_dec
            assign cnt_we[g] = wr_en && (wr_addr == ADDR_W'(g));
            assign rel_we[g] = wr_en && (wr_addr == ADDR_W'(g + BYTES));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         reload_q[g*8 +: 8] <= 8'h00;
                else if (rel_we[g]) reload_q[g*8 +: 8] <= wr_data;
            end
        end
    endgenerate

    assign ovf = tick && run && (cnt_we == '0) && (cnt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we != '0) begin
            for (int b = 0; b < BYTES; b++)
                if (cnt_we[b]) cnt_q[b*8 +: 8] <= wr_data;
        end else if (tick && run) begin
            cnt_q <= (cnt_q == TOP) ? reload_q : cnt_q + 1'b1;
        end
    end

    // R3: an overflow loads the reload value held before that edge
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == $past(reload_q)));
    // R1: outside the mode and without writes the counter holds
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && cnt_we == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/clkout_fsm.sv
module clkout_fsm
    import clkout_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int FLAG_ADR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ovf,
    input  logic              irq_ignore,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              clk_out,
    output logic              ovf_flag,
    output logic              irq
);
    out_state_t state_q, state_d;
    logic flag_clr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PARK_LO: if (run) state_d = ovf ? ST_RUN_HI : ST_RUN_LO;
            ST_PARK_HI: if (run) state_d = ovf ? ST_RUN_LO : ST_RUN_HI;
            ST_RUN_LO:  if (!run)     state_d = ST_PARK_LO;
                        else if (ovf) state_d = ST_RUN_HI;
            ST_RUN_HI:  if (!run)     state_d = ST_PARK_HI;
                        else if (ovf) state_d = ST_RUN_LO;
            default:    state_d = ST_PARK_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PARK_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        clk_out = (state_q == ST_PARK_HI) || (state_q == ST_RUN_HI);
    end

    assign flag_clr = wr_en && (wr_addr == ADDR_W'(FLAG_ADR)) && !wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (ovf)      ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end

    assign irq = ovf_flag && !irq_ignore;

    // R4: output flips on overflow cycles only
    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (clk_out != $past(clk_out)));
    p_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(clk_out));
    // R1: output holds outside the mode
    p_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(clk_out));
    // R5: flag set after every overflow, set beats clear
    p_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf_flag);
    // R6: no request while ignored
    always_comb begin
        if (rst_n && irq_ignore) p_mask_r6: assert (!irq);
    end
endmodule

// File: rtl/clkout_timer.sv
module clkout_timer #(
    parameter int WIDTH = 16,
    localparam int BYTES = WIDTH / 8,
    localparam int ADDR_W = $clog2(2 * BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_rate,
    input  logic              cap_sel,
    input  logic              out_en,
    input  logic              irq_ignore,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              clk_out,
    output logic              ovf_flag,
    output logic              irq
);
    logic tick, run, ovf;

    assign run = !cap_sel && out_en;

    clkout_tick u_tick (
        .clk(clk), .rst_n(rst_n), .full_rate(full_rate), .tick(tick)
    );

    clkout_counter #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ovf(ovf)
    );

    clkout_fsm #(.ADDR_W(ADDR_W), .FLAG_ADR(2 * BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .ovf(ovf),
        .irq_ignore(irq_ignore), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_out(clk_out), .ovf_flag(ovf_flag), .irq(irq)
    );
endmodule

// File: tb/tb_clkout_timer.sv
`timescale 1ns/1ps
module tb_clkout_timer;
    logic clk = 0, rst_n = 0;
    logic full_rate = 1, cap_sel = 0, out_en = 0, irq_ignore = 0;
    logic wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic clk_out, ovf_flag, irq;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    clkout_timer dut (.*);

    always #2.5 clk = ~clk;

    // behavioural reference model
    int m_cnt = 0, m_rel = 0, m_out = 0, m_flag = 0, m_phase = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_out = 0; m_flag = 0; m_phase = 0;
        end else begin
            int tk, ov, old_rel;
            tk = full_rate ? 1 : m_phase;
            m_phase = 1 - m_phase;
            ov = 0;
            old_rel = m_rel;
            if (wr_en && wr_addr == 0)      m_cnt = (m_cnt & 'hFF00) | wr_data;
            else if (wr_en && wr_addr == 1) m_cnt = (m_cnt & 'h00FF) | (wr_data << 8);
            else if (tk && !cap_sel && out_en) begin
                if (m_cnt == 'hFFFF) begin m_cnt = old_rel; ov = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wr_en && wr_addr == 2) m_rel = (m_rel & 'hFF00) | wr_data;
            if (wr_en && wr_addr == 3) m_rel = (m_rel & 'h00FF) | (wr_data << 8);
            if (ov) m_out = 1 - m_out;
            if (ov) m_flag = 1;
            else if (wr_en && wr_addr == 4 && !wr_data[0]) m_flag = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(clk_out == m_out[0], "R4 R7 clk_out vs model", clk_out, m_out);
            chk(ovf_flag == m_flag[0], "R5 flag vs model", ovf_flag, m_flag);
            chk(irq == (m_flag[0] && !irq_ignore), "R6 irq vs model", irq,
                m_flag[0] && !irq_ignore);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic load(input int cnt, input int rel);
        wr(2, rel[7:0]); wr(3, rel[15:8]);
        wr(0, cnt[7:0]); wr(1, cnt[15:8]);
    endtask

    task automatic measure(input int exp, input string tag);
        int n = 0;
        logic prev;
        prev = clk_out;
        forever begin
            @(negedge clk);
            if (!prev && clk_out) break;
            prev = clk_out;
        end
        prev = clk_out;
        forever begin
            @(negedge clk);
            n++;
            if (!prev && clk_out) break;
            prev = clk_out;
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic held;
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(clk_out == 0, "R9 clk_out after reset", clk_out, 0);
        chk(ovf_flag == 0, "R9 flag after reset", ovf_flag, 0);
        chk(irq == 0, "R9 irq after reset", irq, 0);

        // R3 R4: full rate, reload 0xFFF0 -> 32 cycles
        load('hFFF0, 'hFFF0);
        @(posedge clk); #1 out_en = 1;
        measure(32, "R3 R4 period reload FFF0");
        measure(32, "R3 R4 second period reload FFF0");

        // R1: mode off by enable, then by capture select
        @(posedge clk); #1 out_en = 0;
        @(negedge clk); held = clk_out;
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(clk_out == held, "R1 hold with out_en=0", clk_out, held);
        @(posedge clk); #1 begin out_en = 1; cap_sel = 1; end
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(clk_out == held, "R1 hold with cap_sel=1", clk_out, held);
        @(posedge clk); #1 begin out_en = 0; cap_sel = 0; end

        // R6 masking
        @(posedge clk); #1 irq_ignore = 1;
        @(negedge clk);
        chk(ovf_flag == 1, "R6 flag still set", ovf_flag, 1);
        chk(irq == 0, "R6 irq blocked", irq, 0);
        @(posedge clk); #1 irq_ignore = 0;
        @(negedge clk);
        chk(irq == 1, "R6 irq follows flag", irq, 1);

        // R5 clear while stopped
        wr(4, 8'h00);
        @(negedge clk);
        chk(ovf_flag == 0, "R5 flag cleared", ovf_flag, 0);

        // R8: reload FFFF toggles every enable
        load('hFFFF, 'hFFFF);
        @(posedge clk); #1 out_en = 1;
        measure(2, "R8 period reload FFFF");
        // R5 set wins over clear in the same cycle
        wr(4, 8'h00);
        @(negedge clk);
        chk(ovf_flag == 1, "R5 set beats clear", ovf_flag, 1);

        // R2: half rate, reload FFF8 -> 16 enables = 32 cycles
        @(posedge clk); #1 out_en = 0;
        @(posedge clk); #1 full_rate = 0;
        load('hFFF8, 'hFFF8);
        @(posedge clk); #1 out_en = 1;
        measure(32, "R2 half-rate period reload FFF8");
        measure(32, "R2 half-rate second period");

        // R7: reload change applies from the next overflow on
        @(posedge clk); #1 full_rate = 1;
        wr(2, 8'h00); wr(3, 8'hFF);
        measure(512, "R7 R4 period after reload write (first)");
        measure(512, "R7 R4 period after reload write (second)");
        // R7: counter write during run overrides counting
        wr(0, 8'hF0);
        wr(1, 8'hFF);
        repeat (40) @(posedge clk);

        finish_run();
    end
endmodule